// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the address engine of a microprogrammed control unit. It holds the control address register, which points into a fixed 128-word control store. It also holds one return-address register for a single level of micro-subroutine. The control store is computed from constants at elaboration. The word at the current address comes out combinationally as the control word. Its low bits tell the sequencer how to form the next address.

Each microinstruction names one of three status flags, or the constant true. It can invert that choice. It also names a next-address kind: jump, call, return or opcode dispatch. When the qualified condition holds, that kind is carried out on the next rising clock edge. Otherwise the address steps by one. The dispatch kind turns the 4-bit instruction opcode into the first word of that instruction's 4-word routine.

Top module: `micro_seq`

## Requirements
- R1: An active-low asynchronous reset forces the control address to 3 and clears the return register to 0.
- R2: The control word is the store entry at the current address, presented in the same cycle. Its fields are: bits [6:0] target address; bits [8:7] kind (0 jump, 1 call, 2 return, 3 dispatch); bits [10:9] flag select; bit [11] invert; bits [19:12] micro-operations. The micro-operation field always equals {1, address}.
- R3: The condition is true for select 0, and otherwise status[0] (carry) for select 1, status[1] (zero) for select 2 and status[2] (sign) for select 3. The invert bit flips it. When the condition is false, the address becomes address+1 modulo 128.
- R4: A jump with a true condition loads the target field.
- R5: A call with a true condition loads the target field and stores address+1 in the return register.
- R6: A return with a true condition loads the return register. The return register changes only on a call whose condition is true.
- R7: A dispatch with a true condition loads {0, opcode, 00}.
- R8: The store content depends on the address a. Slot a[1:0]=0 is a step (select 0, inverted). Slot 1 is conditional on select a[3:2] with invert a[4]: in the lower half it jumps to {1, a[5:2], 00}, in the upper half it returns. Slot 2 is an unconditional call to 120 in the lower half and an unconditional return in the upper half. Slot 3 is an unconditional dispatch. As a result, with opcode 0 after reset the address runs 3, 0, 1, 64, 65, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Instruction opcode used by dispatch |
| status | input | 3 | Flags: sign, zero, carry (bit 0) |
| ctrlWord | output | 20 | Control word at the current address |
| car | output | 7 | Current control address |

## Verification
The hardest case to reach from the ports is a return taken while the return register still holds its reset value, or a value left over from an older call. The fixed store only reaches returns along particular paths. The stimulus steers those paths through the opcode: each dispatch picks a 4-word group, and that group's slot-1 word fixes which flag and which polarity gate the branch. A status pattern chosen for that group then decides between branching and falling through to the call. The bench keeps its own copy of the return register, updated only by taken calls, so stale-value returns are predicted exactly.

// File: rtl/micro_seq_pkg.sv
package micro_seq_pkg;
  localparam int ADDR_W = 7;
  localparam int OP_W = 4;
  localparam int STAT_W = 3;
  localparam int UOP_W = ADDR_W + 1;
  localparam int WORD_W = UOP_W + 1 + 2 + 2 + ADDR_W;
  localparam logic [ADDR_W-1:0] SUB_ENTRY = 7'd120;

  typedef enum logic [1:0] {
    KIND_JUMP = 2'd0,
    KIND_CALL = 2'd1,
    KIND_RET  = 2'd2,
    KIND_MAP  = 2'd3
  } nextKind_t;

  typedef struct packed {
    logic [UOP_W-1:0]  uop;
    logic              invert;
    logic [1:0]        condSel;
    nextKind_t         kind;
    logic [ADDR_W-1:0] target;
  } uword_t;

  typedef struct packed {
    logic takeTarget;
    logic takeMap;
    logic takeReturn;
    logic saveReturn;
  } seqStrobe_t;

  // Fixed microprogram, derived from the address alone.
  function automatic uword_t romWord(input logic [ADDR_W-1:0] a);
    uword_t w;
    w.uop     = {1'b1, a};
    w.invert  = 1'b0;
    w.condSel = 2'd0;
    w.kind    = KIND_JUMP;
    w.target  = '0;
    case (a[1:0])
      2'd0: w.invert = 1'b1;
      2'd1: begin
        w.invert  = a[4];
        w.condSel = a[3:2];
        if (a[6]) begin
          w.kind = KIND_RET;
        end else begin
          w.kind   = KIND_JUMP;
          w.target = {1'b1, a[5:2], 2'b00};
        end
      end
      2'd2: begin
        if (a[6]) begin
          w.kind = KIND_RET;
        end else begin
          w.kind   = KIND_CALL;
          w.target = SUB_ENTRY;
        end
      end
      default: w.kind = KIND_MAP;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/micro_seq_rom.sv
module micro_seq_rom
  import micro_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  localparam int DEPTH = 1 << ADDR_W;

  uword_t romArr [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      assign romArr[i] = romWord(ADDR_W'(i));
    end
  endgenerate

  assign word = romArr[addr];
endmodule

// File: rtl/micro_seq_ctrl.sv
module micro_seq_ctrl
  import micro_seq_pkg::*;
(
  input  nextKind_t         kind,
  input  logic [1:0]        condSel,
  input  logic              invert,
  input  logic [STAT_W-1:0] status,
  output seqStrobe_t        strobe
);
  logic flag;
  logic condMet;

  always_comb begin
    case (condSel)
      2'd0:    flag = 1'b1;
      2'd1:    flag = status[0];
      2'd2:    flag = status[1];
      default: flag = status[2];
    endcase
    condMet = flag ^ invert;
  end

  always_comb begin
    strobe = '0;
    if (condMet) begin
      case (kind)
        KIND_JUMP: strobe.takeTarget = 1'b1;
        KIND_CALL: begin
          strobe.takeTarget = 1'b1;
          strobe.saveReturn = 1'b1;
        end
        KIND_RET: strobe.takeReturn = 1'b1;
        default:  strobe.takeMap = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/micro_seq_path.sv
module micro_seq_path
  import micro_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 7'd3,
  parameter int MAP_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] target,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] car
);
  localparam int PAD_W = ADDR_W - OP_W - MAP_LSB;

  logic [ADDR_W-1:0] sbr;
  logic [ADDR_W-1:0] carInc;
  logic [ADDR_W-1:0] mapped;
  logic [ADDR_W-1:0] nextCar;

  assign carInc = car + ADDR_W'(1);
  assign mapped = {{PAD_W{1'b0}}, opcode, {MAP_LSB{1'b0}}};

  always_comb begin
    if (strobe.takeReturn)      nextCar = sbr;
    else if (strobe.takeMap)    nextCar = mapped;
    else if (strobe.takeTarget) nextCar = target;
    else                        nextCar = carInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      car <= START_ADDR;
      sbr <= '0;
    end else begin
      car <= nextCar;
      if (strobe.saveReturn) sbr <= carInc;
    end
  end

  // R3: a false condition steps the address by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takeTarget || strobe.takeMap || strobe.takeReturn)
    |=> car == $past(car) + ADDR_W'(1));

  // R4
  a_r4_jump: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeTarget |=> car == $past(target));

  // R5
  a_r5_call_saves: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveReturn |=> sbr == $past(car) + ADDR_W'(1));

  // R6
  a_r6_return: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeReturn |=> car == $past(sbr));

  a_r6_sbr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveReturn |=> $stable(sbr));

  // R7
  a_r7_map: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeMap |=> car == {1'b0, $past(opcode), 2'b00});
endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import micro_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 7'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [STAT_W-1:0] status,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [ADDR_W-1:0] car
);
  uword_t     word;
  seqStrobe_t strobe;

  micro_seq_rom u_rom (
    .addr(car),
    .word(word)
  );

  micro_seq_ctrl u_ctrl (
    .kind(word.kind),
    .condSel(word.condSel),
    .invert(word.invert),
    .status(status),
    .strobe(strobe)
  );

  micro_seq_path #(.START_ADDR(START_ADDR), .MAP_LSB(2)) u_path (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .target(word.target),
    .opcode(opcode),
    .car(car)
  );

  assign ctrlWord = word;
endmodule

// File: tb/micro_seq_test.sv
module micro_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [3:0] opcode = 4'd0;
  logic [2:0] status = 3'd0;
  logic [19:0] ctrlWord;
  logic [6:0]  car;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [6:0] sbrModel = 7'd0;

  micro_seq uut (
    .clk(clk), .rstN(rstN), .opcode(opcode), .status(status),
    .ctrlWord(ctrlWord), .car(car)
  );

  always #2.5 clk = ~clk;

  // {opcode, status} stimulus vectors
  localparam logic [6:0] VEC [24] = '{
    {4'd5, 3'b001}, {4'd5, 3'b000}, {4'd1, 3'b001}, {4'd1, 3'b000},
    {4'd2, 3'b010}, {4'd2, 3'b000}, {4'd3, 3'b100}, {4'd3, 3'b000},
    {4'd6, 3'b010}, {4'd6, 3'b000}, {4'd7, 3'b100}, {4'd7, 3'b000},
    {4'd4, 3'b111}, {4'd9, 3'b001}, {4'd10, 3'b010}, {4'd11, 3'b100},
    {4'd13, 3'b110}, {4'd14, 3'b101}, {4'd15, 3'b011}, {4'd8, 3'b000},
    {4'd12, 3'b111}, {4'd0, 3'b010}, {4'd15, 3'b000}, {4'd13, 3'b001}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive one cycle and predict the next address from the visible word.
  task automatic step(input logic [3:0] op, input logic [2:0] st);
    logic [19:0] w;
    logic [6:0] c, expCar;
    logic flag, met;
    string tag;
    opcode = op;
    status = st;
    #1;
    w = ctrlWord;
    c = car;
    check(w[19:12] == {1'b1, c}, "R2 uop field", w[19:12], {1'b1, c});
    if (c[1:0] == 2'd3)
      check(w[11:7] == 5'b00011, "R8 slot3 dispatch", w[11:7], 3);
    case (w[10:9])
      2'd0: flag = 1'b1;
      2'd1: flag = st[0];
      2'd2: flag = st[1];
      default: flag = st[2];
    endcase
    met = flag ^ w[11];
    if (!met) begin
      expCar = c + 7'd1; tag = "R3 step";
    end else begin
      case (w[8:7])
        2'd0: begin expCar = w[6:0]; tag = "R4 jump"; end
        2'd1: begin expCar = w[6:0]; tag = "R5 call"; end
        2'd2: begin expCar = sbrModel; tag = "R6 return"; end
        default: begin expCar = {1'b0, op, 2'b00}; tag = "R7 dispatch"; end
      endcase
    end
    @(negedge clk);
    if (met && w[8:7] == 2'd1) sbrModel = c + 7'd1;
    check(car == expCar, tag, car, expCar);
  endtask

  initial begin
    #1 rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(car == 7'd3, "R1 reset address", car, 3);
    check(ctrlWord[8:7] == 2'd3, "R2 word at reset address", ctrlWord[8:7], 3);
    rstN = 1'b1;
    sbrModel = 7'd0;

    // R8: fixed path with opcode 0, return to cleared register
    opcode = 4'd0;
    status = 3'd0;
    @(negedge clk); check(car == 7'd0, "R8 path", car, 0);
    @(negedge clk); check(car == 7'd1, "R8 path", car, 1);
    @(negedge clk); check(car == 7'd64, "R8 path", car, 64);
    @(negedge clk); check(car == 7'd65, "R8 path", car, 65);
    @(negedge clk); check(car == 7'd0, "R8 return to cleared register", car, 0);

    for (int pass = 0; pass < 4; pass++) begin
      for (int i = 0; i < 24; i++) begin
        step(VEC[i][6:3], VEC[i][2:0]);
      end
    end

    // R1: asynchronous reset in mid-cycle
    #1 rstN = 1'b0;
    #1;
    check(car == 7'd3, "R1 async reset", car, 3);
    @(negedge clk);
    rstN = 1'b1;
    sbrModel = 7'd0;
    for (int i = 0; i < 24; i++) begin
      step(VEC[23 - i][6:3], VEC[23 - i][2:0]);
    end
    finish_run();
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule